// File: doc/BRIEF.md
# Branch prediction history queue

This block keeps one record for each predicted branch that is still in flight. It has one queue per hardware thread. Predictions are appended at the young end of the queue. A commit retires records from the old end and sends each one to the direction predictor as a training strobe. A squash discards records from the young end. For each discarded record it emits the return-stack repair that undoes the speculation the record made. On a misprediction it then retrains the predictor and the target buffer from the record of the offending branch.

Each record holds:
- a 16-bit sequence number;
- the branch PC;
- the predicted direction;
- an opaque predictor-history tag;
- a return-stack-used flag, with the saved stack index and top target;
- a was-call flag.

The block handles one commit or squash operation at a time and processes one record per clock. The predictor tables, target buffer and return stack are outside the block. The block only drives their update and repair strobes, which are combinational from its registered state.

Top module: `bpred_hist_queue`

## Requirements
- R1: After reset every queue is empty, `op_ready` and `ins_ready` are 1, and `upd_valid`, `btb_valid`, `ras_restore` and `ras_pop` are 0.
- R2: While `ins_ready` is 1, `ins_valid` appends a record at the young end of the queue of thread `ins_tid`. `ins_ready` is 0 while that queue holds DEPTH (16) records, and a refused insert leaves the queue unchanged.
- R3: A commit with number N removes records from the old end, one per cycle, while their sequence number is at most N. Each removal drives `upd_valid`=1 with that record's PC, predicted direction and history tag. The commit stops at the first record that is younger than N.
- R4: A squash with number S removes records from the young end, one per cycle, while their sequence number is greater than S. These removals never assert `upd_valid`.
- R5: A squashed record whose used flag is set drives `ras_restore`=1 with its saved `ras_idx` and `ras_tgt`, whether or not it was a call.
- R6: A squashed record that was a call without stack use drives `ras_pop`=1. A squashed record with neither flag set drives no stack command.
- R7: On a mispredict squash, after the younger records are gone, if the young-end record's number equals S it is removed in one cycle. In that cycle `upd_valid` carries the actual direction and `btb_valid` carries the corrected target with the record's PC. If no record equals S, nothing more is emitted.
- R8: Queues of different threads are independent, and `act_tid` names the thread that the strobes belong to.
- R9: When a squash and a commit are presented in the same idle cycle, only the squash is performed and the commit is discarded.
- R10: `op_ready` is 0 while an operation runs. Commit and squash requests seen while busy are ignored, and inserts to the busy thread are refused.
- R11: Sequence numbers compare as plain unsigned values, with no wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert a prediction record |
| ins_ready | output | 1 | Insert accepted this cycle |
| ins_tid | input | TW | Thread of the insert |
| ins_seq | input | SEQ_W | Sequence number |
| ins_pc | input | PC_W | Branch PC |
| ins_taken | input | 1 | Predicted direction |
| ins_hist | input | HIST_W | Predictor history tag |
| ins_used_ras | input | 1 | Prediction read the return stack |
| ins_ras_idx | input | RI_W | Saved stack top index |
| ins_ras_tgt | input | PC_W | Saved stack top entry |
| ins_call | input | 1 | Branch is a call |
| cmt_valid | input | 1 | Commit request |
| cmt_tid | input | TW | Commit thread |
| cmt_seq | input | SEQ_W | Done sequence number |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TW | Squash thread |
| sq_seq | input | SEQ_W | Squash sequence number |
| sq_mispredict | input | 1 | Squash carries a resolved branch |
| sq_taken | input | 1 | Actual direction |
| sq_target | input | PC_W | Corrected target |
| op_ready | output | 1 | No operation in progress |
| act_tid | output | TW | Thread of the running operation |
| upd_valid | output | 1 | Direction predictor update strobe |
| upd_pc | output | PC_W | Update PC |
| upd_taken | output | 1 | Update direction |
| upd_hist | output | HIST_W | Update history tag |
| btb_valid | output | 1 | Target buffer update strobe |
| btb_pc | output | PC_W | Target buffer PC |
| btb_target | output | PC_W | Target buffer target |
| ras_restore | output | 1 | Restore stack top |
| ras_pop | output | 1 | Pop speculative push |
| ras_idx | output | RI_W | Index to restore |
| ras_tgt | output | PC_W | Entry to restore |

## Verification
One thread's queue is filled to capacity with records whose flags cycle through stack-used, call-only and plain. A short second queue holds distinct numbers so that cross-thread leakage is visible. Commits with a mid-queue number, a number below the oldest record and the maximum number show where retirement stops. Plain and mispredict squashes, including a mispredict whose number matches no record, separate the stack-restore, pop and retrain paths. Simultaneous requests, requests during a busy operation, and numbers at 0 and 65535 expose priority errors, dropped-request errors and any wraparound in the compare.

// File: rtl/bpred_hist_queue.sv
module bpred_hist_queue #(
  parameter int THREADS = 2,
  parameter int DEPTH   = 16,
  parameter int SEQ_W   = 16,
  parameter int PC_W    = 32,
  parameter int HIST_W  = 8,
  parameter int RI_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [TW-1:0]     ins_tid,
  input  logic [SEQ_W-1:0]  ins_seq,
  input  logic [PC_W-1:0]   ins_pc,
  input  logic              ins_taken,
  input  logic [HIST_W-1:0] ins_hist,
  input  logic              ins_used_ras,
  input  logic [RI_W-1:0]   ins_ras_idx,
  input  logic [PC_W-1:0]   ins_ras_tgt,
  input  logic              ins_call,
  input  logic              cmt_valid,
  input  logic [TW-1:0]     cmt_tid,
  input  logic [SEQ_W-1:0]  cmt_seq,
  input  logic              sq_valid,
  input  logic [TW-1:0]     sq_tid,
  input  logic [SEQ_W-1:0]  sq_seq,
  input  logic              sq_mispredict,
  input  logic              sq_taken,
  input  logic [PC_W-1:0]   sq_target,
  output logic              op_ready,
  output logic [TW-1:0]     act_tid,
  output logic              upd_valid,
  output logic [PC_W-1:0]   upd_pc,
  output logic              upd_taken,
  output logic [HIST_W-1:0] upd_hist,
  output logic              btb_valid,
  output logic [PC_W-1:0]   btb_pc,
  output logic [PC_W-1:0]   btb_target,
  output logic              ras_restore,
  output logic              ras_pop,
  output logic [RI_W-1:0]   ras_idx,
  output logic [PC_W-1:0]   ras_tgt
);
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [SEQ_W-1:0]  seq;
    logic [PC_W-1:0]   pc;
    logic              taken;
    logic [HIST_W-1:0] hist;
    logic              used_ras;
    logic [RI_W-1:0]   ras_idx;
    logic [PC_W-1:0]   ras_tgt;
    logic              call;
  } rec_t;

  typedef enum logic [1:0] {IDLE, DRAIN_OLD, DRAIN_YNG} op_t;

  rec_t            mem  [THREADS][DEPTH];
  logic [PW-1:0]   head [THREADS];
  logic [CW-1:0]   cnt  [THREADS];

  op_t              op;
  logic [TW-1:0]    op_tid;
  logic [SEQ_W-1:0] op_seq;
  logic             op_misp, op_taken;
  logic [PC_W-1:0]  op_tgt;

  rec_t          old_r, yng_r;
  logic          nonempty, cmt_pop, sq_pop, fix_pop, ins_fire;
  logic [PW-1:0] wr_idx, yng_idx;

  assign yng_idx  = head[op_tid] + cnt[op_tid][PW-1:0] - PW'(1);
  assign old_r    = mem[op_tid][head[op_tid]];
  assign yng_r    = mem[op_tid][yng_idx];
  assign nonempty = cnt[op_tid] != '0;

  assign cmt_pop = (op == DRAIN_OLD) && nonempty && (old_r.seq <= op_seq);
  assign sq_pop  = (op == DRAIN_YNG) && nonempty && (yng_r.seq > op_seq);
  assign fix_pop = (op == DRAIN_YNG) && op_misp && nonempty && (yng_r.seq == op_seq);

  assign op_ready  = (op == IDLE);
  assign act_tid   = op_tid;
  assign ins_ready = (cnt[ins_tid] != CW'(DEPTH)) && (op_ready || op_tid != ins_tid);
  assign ins_fire  = ins_valid && ins_ready;
  assign wr_idx    = head[ins_tid] + cnt[ins_tid][PW-1:0];

  assign upd_valid   = cmt_pop || (fix_pop && !sq_pop);
  assign upd_pc      = cmt_pop ? old_r.pc : yng_r.pc;
  assign upd_taken   = cmt_pop ? old_r.taken : op_taken;
  assign upd_hist    = cmt_pop ? old_r.hist : yng_r.hist;
  assign btb_valid   = fix_pop && !sq_pop;
  assign btb_pc      = yng_r.pc;
  assign btb_target  = op_tgt;
  assign ras_restore = sq_pop && yng_r.used_ras;
  assign ras_pop     = sq_pop && !yng_r.used_ras && yng_r.call;
  assign ras_idx     = yng_r.ras_idx;
  assign ras_tgt     = yng_r.ras_tgt;

  always_ff @(posedge clk) begin
    if (ins_fire) begin
      mem[ins_tid][wr_idx] <= '{seq: ins_seq, pc: ins_pc, taken: ins_taken,
                                hist: ins_hist, used_ras: ins_used_ras,
                                ras_idx: ins_ras_idx, ras_tgt: ins_ras_tgt,
                                call: ins_call};
    end
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < THREADS; t++) begin
      if (!rst_n) begin
        head[t] <= '0;
        cnt[t]  <= '0;
      end else if (ins_fire && ins_tid == TW'(t)) begin
        cnt[t] <= cnt[t] + CW'(1);
      end else if (op_tid == TW'(t) && cmt_pop) begin
        head[t] <= head[t] + PW'(1);
        cnt[t]  <= cnt[t] - CW'(1);
      end else if (op_tid == TW'(t) && (sq_pop || fix_pop)) begin
        cnt[t] <= cnt[t] - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op       <= IDLE;
      op_tid   <= '0;
      op_seq   <= '0;
      op_misp  <= 1'b0;
      op_taken <= 1'b0;
      op_tgt   <= '0;
    end else begin
      case (op)
        IDLE:
          if (sq_valid) begin
            op       <= DRAIN_YNG;
            op_tid   <= sq_tid;
            op_seq   <= sq_seq;
            op_misp  <= sq_mispredict;
            op_taken <= sq_taken;
            op_tgt   <= sq_target;
          end else if (cmt_valid) begin
            op      <= DRAIN_OLD;
            op_tid  <= cmt_tid;
            op_seq  <= cmt_seq;
            op_misp <= 1'b0;
          end
        DRAIN_OLD: if (!cmt_pop) op <= IDLE;
        DRAIN_YNG: if (!sq_pop) op <= IDLE;
        default:   op <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hq_chk.sv
module hq_chk #(
  parameter int TW = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_ready,
  input logic          sq_valid,
  input logic [TW-1:0] ins_tid,
  input logic          ins_ready,
  input logic [TW-1:0] act_tid,
  input logic          upd_valid,
  input logic          btb_valid,
  input logic          ras_restore,
  input logic          ras_pop
);
  // R4
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ras_restore, ras_pop, upd_valid}));

  // R7
  btb_with_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btb_valid |-> upd_valid);

  // R7
  fix_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btb_valid |=> op_ready);

  // R10
  busy_thread_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_ready && ins_tid == act_tid) |-> !ins_ready);

  // R9
  squash_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ready && sq_valid) |=> !op_ready);

  // R6
  ras_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_restore || ras_pop) |-> !op_ready);
endmodule

bind bpred_hist_queue hq_chk #(.TW(TW)) u_hq_chk (
  .clk(clk), .rst_n(rst_n), .op_ready(op_ready), .sq_valid(sq_valid),
  .ins_tid(ins_tid), .ins_ready(ins_ready), .act_tid(act_tid),
  .upd_valid(upd_valid), .btb_valid(btb_valid),
  .ras_restore(ras_restore), .ras_pop(ras_pop)
);

// File: tb/test_bpred_hist_queue.sv
module test_bpred_hist_queue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        ins_valid = 0, ins_ready, ins_tid = 0, ins_taken = 0, ins_used_ras = 0, ins_call = 0;
  logic [15:0] ins_seq = 0;
  logic [31:0] ins_pc = 0, ins_ras_tgt = 0;
  logic [7:0]  ins_hist = 0;
  logic [3:0]  ins_ras_idx = 0;
  logic        cmt_valid = 0, cmt_tid = 0, sq_valid = 0, sq_tid = 0, sq_mispredict = 0, sq_taken = 0;
  logic [15:0] cmt_seq = 0, sq_seq = 0;
  logic [31:0] sq_target = 0;
  logic        op_ready, act_tid, upd_valid, upd_taken, btb_valid, ras_restore, ras_pop;
  logic [31:0] upd_pc, btb_pc, btb_target, ras_tgt;
  logic [7:0]  upd_hist;
  logic [3:0]  ras_idx;

  bpred_hist_queue i_bpred_hist_queue (.*);

  int n_chk = 0, n_fail = 0;
  int m_n [2];
  logic [15:0] ms [2][20];
  logic [31:0] mp [2][20], mg [2][20];
  logic [7:0]  mh [2][20];
  logic [3:0]  mi [2][20];
  logic        mt [2][20], mu [2][20], mc [2][20];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ins(input int t, input int i, input logic [15:0] s, input bit expect_ok);
    ins_valid = 1; ins_tid = t[0]; ins_seq = s;
    ins_pc = 32'h400 + 32'(i * 4) + 32'(t * 32'h10000);
    ins_taken = i[0]; ins_hist = 8'(i * 7 + t);
    ins_used_ras = (i % 3 == 0); ins_call = (i % 3 != 2);
    ins_ras_idx = 4'(i); ins_ras_tgt = 32'h9000 + 32'(i * 16);
    #1;
    chk("R2 ins_ready", ins_ready, expect_ok);
    if (ins_ready) begin
      ms[t][m_n[t]] = s; mp[t][m_n[t]] = ins_pc; mt[t][m_n[t]] = ins_taken;
      mh[t][m_n[t]] = ins_hist; mu[t][m_n[t]] = ins_used_ras; mc[t][m_n[t]] = ins_call;
      mi[t][m_n[t]] = ins_ras_idx; mg[t][m_n[t]] = ins_ras_tgt;
      m_n[t]++;
    end
    @(posedge clk); @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic pop_old(input int t);
    for (int k = 0; k < 19; k++) begin
      ms[t][k] = ms[t][k+1]; mp[t][k] = mp[t][k+1]; mt[t][k] = mt[t][k+1];
      mh[t][k] = mh[t][k+1]; mu[t][k] = mu[t][k+1]; mc[t][k] = mc[t][k+1];
      mi[t][k] = mi[t][k+1]; mg[t][k] = mg[t][k+1];
    end
    m_n[t]--;
  endtask

  // is_sq: squash; both: also present a commit (R9)
  task automatic run_op(input bit is_sq, input bit both, input int t, input logic [15:0] s,
                        input bit misp, input bit act, input logic [31:0] tgt);
    bit done = 0;
    sq_valid = is_sq; sq_tid = t[0]; sq_seq = s; sq_mispredict = misp; sq_taken = act; sq_target = tgt;
    cmt_valid = !is_sq || both; cmt_tid = t[0]; cmt_seq = both ? 16'hFFFF : s;
    @(posedge clk); @(negedge clk);
    sq_valid = 0; cmt_valid = 0;
    for (int k = 0; k < 40; k++) begin
      if (k == 0) begin
        ins_tid = t[0]; cmt_valid = 1; cmt_tid = !t[0]; cmt_seq = 16'hFFFF;
        #1;
        chk("R10 busy", op_ready, 0);
        chk("R10 insert to busy thread", ins_ready, 0);
      end else #1;
      if (op_ready) begin done = 1; break; end
      chk("R8 act_tid", act_tid, t[0]);
      if (!is_sq) begin
        if (m_n[t] > 0 && ms[t][0] <= s) begin
          chk("R3 strobes", {upd_valid, btb_valid, ras_restore, ras_pop}, 4'b1000);
          chk("R3 pc", upd_pc, mp[t][0]);
          chk("R3 dir/hist", {upd_taken, upd_hist}, {mt[t][0], mh[t][0]});
          pop_old(t);
        end else
          chk("R3 stop", {upd_valid, btb_valid, ras_restore, ras_pop}, 4'b0000);
      end else begin
        int y = m_n[t] - 1;
        if (m_n[t] > 0 && ms[t][y] > s) begin
          chk("R4 R5 R6 strobes", {upd_valid, btb_valid, ras_restore, ras_pop},
              {2'b00, mu[t][y], !mu[t][y] && mc[t][y]});
          if (mu[t][y]) chk("R5 restore data", {ras_idx, ras_tgt}, {mi[t][y], mg[t][y]});
          m_n[t]--;
        end else if (misp && m_n[t] > 0 && ms[t][y] == s) begin
          chk("R7 strobes", {upd_valid, btb_valid, ras_restore, ras_pop}, 4'b1100);
          chk("R7 upd", {upd_pc, upd_taken, upd_hist}, {mp[t][y], act, mh[t][y]});
          chk("R7 btb", {btb_pc, btb_target}, {mp[t][y], tgt});
          m_n[t]--;
        end else
          chk("R4 R7 stop", {upd_valid, btb_valid, ras_restore, ras_pop}, 4'b0000);
      end
      @(posedge clk); @(negedge clk);
      cmt_valid = 0;
    end
    cmt_valid = 0;
    if (!done) chk("R10 op never ended", 0, 1);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_n[0] = 0; m_n[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk("R1 idle", {op_ready, ins_ready}, 2'b11);
    chk("R1 strobes", {upd_valid, btb_valid, ras_restore, ras_pop}, 4'b0000);
    for (int i = 0; i < 16; i++) ins(0, i, 16'(10 * (i + 1)), 1);
    ins(0, 16, 16'd170, 0);                                 // R2 full
    for (int i = 0; i < 3; i++) ins(1, i, 16'(5 + i), 1);   // R8
    run_op(0, 0, 0, 16'd35, 0, 0, 0);                       // R3
    run_op(1, 0, 0, 16'd125, 0, 0, 0);                      // R4 R5 R6
    run_op(1, 0, 0, 16'd100, 1, !mt[0][m_n[0]-3], 32'hBEEF0); // R7
    run_op(1, 0, 0, 16'd75, 1, 1, 32'h1234);                // R7 no match
    run_op(1, 1, 0, 16'd65, 0, 0, 0);                       // R9
    run_op(0, 0, 0, 16'd5, 0, 0, 0);                        // R3 nothing
    run_op(0, 0, 1, 16'hFFFF, 0, 0, 0);                     // R8 R10
    ins(1, 4, 16'd0, 1);
    ins(1, 5, 16'd65000, 1);
    ins(1, 6, 16'd65535, 1);
    run_op(1, 0, 1, 16'd65000, 0, 0, 0);                    // R11
    run_op(0, 0, 1, 16'd0, 0, 0, 0);                        // R11
    run_op(0, 0, 0, 16'hFFFF, 0, 0, 0);
    run_op(0, 0, 1, 16'hFFFF, 0, 0, 0);
    chk("R2 drained", m_n[0] + m_n[1], 0);
    for (int i = 0; i < 16; i++) ins(1, i, 16'(i), 1);      // R2 refill
    ins(1, 3, 16'd99, 0);
    run_op(1, 0, 1, 16'd0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule